// File: doc/BRIEF.md
# Dual-Mode Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a signal-processing core. Each cycle it accepts one operation command together with two 32-bit operand words and takes one of three actions. In dual mode it runs two independent 16x16 multiply-accumulates into two 40-bit accumulators. In wide mode it runs one 32x32 multiply-accumulate into a 72-bit accumulator formed by joining the two. In complex mode it runs a 16-bit complex multiply-accumulate, with the real part in the high half of each operand word and the imaginary part in the low half. Instruction decode and the register file sit outside the block. They supply the half selects, the signed/unsigned choice and the clear flag with every command.

Both accumulators appear on raw outputs. Each one also has a read-out path that saturates it to the signed 32-bit range, plus a 16-bit high-half result that can optionally be rounded. A sticky flag per accumulator records that its value has left the 32-bit range. All four 17x17 multipliers are shared by the three modes.

Top module: `dmac_unit`

## Requirements
- R1: Dual mode (op_mode 2'b00, and also the unused code 2'b11): when op_valid is high, accumulator k (k = 0, 1) adds the product of one half of opa and one half of opb. op_sel bit 0 picks the opa half for lane 0, bit 1 the opb half for lane 0, bit 2 the opa half for lane 1 and bit 3 the opb half for lane 1. A 1 selects bits 31:16 and a 0 selects bits 15:0.
- R2: When op_signed is 1, operands in dual and wide modes are two's complement. When it is 0 they are unsigned and zero-extended.
- R3: Wide mode (op_mode 2'b01): the 72-bit value {acc1_o[31:0], acc0_o} adds the 32x32 product of opa and opb. This value is visible on wide_o. After the operation, acc1_o[39:32] are copies of acc1_o[31].
- R4: Complex mode (op_mode 2'b10): the operands are always signed, with the real part in bits 31:16 and the imaginary part in bits 15:0. acc0 adds re_a*re_b - im_a*im_b and acc1 adds re_a*im_b + im_a*re_b.
- R5: With op_clear high, a valid operation loads its product contribution into the accumulators instead of adding it to their old value.
- R6: While op_valid is low, the accumulators and overflow flags keep their values, whatever the other inputs do.
- R7: Accumulator updates appear on the outputs on the clock edge that samples the operation. out_valid is high in exactly the cycles that follow a cycle with op_valid high.
- R8: rdk_o is accumulator k clamped to the range -2^31 to 2^31-1: 0x7FFFFFFF above that range, 0x80000000 below it, and bits 31:0 of the accumulator within it.
- R9: hik_o is bits 31:16 of the clamped value of (accumulator k + 0x8000) when rnd_en is 1, and of accumulator k when rnd_en is 0.
- R10: ovfk_o is set by a dual or complex operation that leaves accumulator k outside the signed 32-bit range. It stays set until a valid operation with op_clear high clears it. A clearing dual or complex operation then re-evaluates the flag on its new result. Wide operations without clear leave both flags unchanged.
- R11: While rst_n is low, both accumulators are zero and out_valid and both overflow flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_mode | input | 2 | 00 dual, 01 wide, 10 complex, 11 dual |
| op_signed | input | 1 | Signed operands (dual and wide modes) |
| op_clear | input | 1 | Load instead of accumulate; clears flags |
| op_sel | input | 4 | Half selects for the dual-mode lanes |
| opa | input | 32 | First operand word |
| opb | input | 32 | Second operand word |
| rnd_en | input | 1 | Round the 16-bit high-half results |
| acc0_o | output | 40 | Accumulator 0 |
| acc1_o | output | 40 | Accumulator 1 |
| wide_o | output | 72 | Joined wide accumulator |
| rd0_o | output | 32 | Saturated read-out of accumulator 0 |
| rd1_o | output | 32 | Saturated read-out of accumulator 1 |
| hi0_o | output | 16 | High-half result of accumulator 0 |
| hi1_o | output | 16 | High-half result of accumulator 1 |
| ovf0_o | output | 1 | Sticky overflow flag, accumulator 0 |
| ovf1_o | output | 1 | Sticky overflow flag, accumulator 1 |
| out_valid | output | 1 | An operation was issued last cycle |

## Verification
The bench drives the most negative 16-bit value in signed multiplies and full-scale unsigned 16-bit and 32-bit products. A design that sign-extends unsigned halves or drops the guard bits gets these accumulators wrong. It also accumulates past the 32-bit range in both directions, so a saturation clamp that picks the wrong limit, or an overflow flag that is not sticky or survives a clear, shows up on the read-out ports. The wide-mode products carry into the upper accumulator, which exposes a bad partial-product shift or a missing sign extension in acc1. It also checks a rounding point at exactly one half LSB, complex products with mixed signs, idle cycles with changing operands, and an asynchronous reset in the middle of the run.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL = 2'b00,
    MODE_WIDE = 2'b01,
    MODE_CPLX = 2'b10,
    MODE_RSVD = 2'b11
  } mac_mode_e;

  localparam int NUM_MULT = 4;
  localparam int NUM_ACC  = 2;
endpackage

// File: rtl/dmac_mul.sv
module dmac_mul #(
  parameter int XW = 17
) (
  input  logic signed [XW-1:0]   mx,
  input  logic signed [XW-1:0]   my,
  output logic signed [2*XW-1:0] prod
);
  assign prod = mx * my;
endmodule

// File: rtl/dmac_route.sv
module dmac_route
  import dmac_pkg::*;
#(
  parameter int HW = 16
) (
  input  mac_mode_e                   mode,
  input  logic                        sgn,
  input  logic [3:0]                  sel,
  input  logic [2*HW-1:0]             opa,
  input  logic [2*HW-1:0]             opb,
  output logic [NUM_MULT-1:0][HW:0]   mx,
  output logic [NUM_MULT-1:0][HW:0]   my
);
  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;

  assign a_hi = opa[2*HW-1:HW];
  assign a_lo = opa[HW-1:0];
  assign b_hi = opb[2*HW-1:HW];
  assign b_lo = opb[HW-1:0];

  function automatic logic [HW:0] ext(input logic [HW-1:0] h, input logic s);
    return {s & h[HW-1], h};
  endfunction

  always_comb begin
    mx = '0;
    my = '0;
    case (mode)
      MODE_WIDE: begin
        mx[0] = ext(a_lo, 1'b0); my[0] = ext(b_lo, 1'b0);
        mx[1] = ext(a_hi, sgn);  my[1] = ext(b_hi, sgn);
        mx[2] = ext(a_hi, sgn);  my[2] = ext(b_lo, 1'b0);
        mx[3] = ext(a_lo, 1'b0); my[3] = ext(b_hi, sgn);
      end
      MODE_CPLX: begin
        mx[0] = ext(a_hi, 1'b1); my[0] = ext(b_hi, 1'b1);
        mx[1] = ext(a_lo, 1'b1); my[1] = ext(b_lo, 1'b1);
        mx[2] = ext(a_hi, 1'b1); my[2] = ext(b_lo, 1'b1);
        mx[3] = ext(a_lo, 1'b1); my[3] = ext(b_hi, 1'b1);
      end
      default: begin
        mx[0] = ext(sel[0] ? a_hi : a_lo, sgn);
        my[0] = ext(sel[1] ? b_hi : b_lo, sgn);
        mx[1] = ext(sel[2] ? a_hi : a_lo, sgn);
        my[1] = ext(sel[3] ? b_hi : b_lo, sgn);
      end
    endcase
  end
endmodule

// File: rtl/dmac_acc.sv
module dmac_acc
  import dmac_pkg::*;
#(
  parameter int HW    = 16,
  parameter int GUARD = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  mac_mode_e                            mode,
  input  logic                                 clr,
  input  logic [NUM_MULT-1:0][2*(HW+1)-1:0]    prod,
  output logic [2*HW+GUARD-1:0]                acc0,
  output logic [2*HW+GUARD-1:0]                acc1,
  output logic                                 ovf0,
  output logic                                 ovf1
);
  localparam int PW  = 2 * (HW + 1);
  localparam int RW  = 2 * HW;
  localparam int ACW = RW + GUARD;
  localparam int WW  = 4 * HW + GUARD;
  localparam int UPW = WW - ACW;

  logic [ACW-1:0] acc0_q, acc1_q, acc0_d, acc1_d, base0, base1;
  logic           ovf0_q, ovf1_q, ovf0_d, ovf1_d;
  logic [WW-1:0]  wbase, wprod, wsum;

  function automatic logic [ACW-1:0] ext_a(input logic [PW-1:0] v);
    return {{(ACW-PW){v[PW-1]}}, v};
  endfunction

  function automatic logic [WW-1:0] ext_w(input logic [PW-1:0] v);
    return {{(WW-PW){v[PW-1]}}, v};
  endfunction

  function automatic logic out_of_range(input logic [ACW-1:0] v);
    return v[ACW-1:RW-1] != {(ACW-RW+1){v[RW-1]}};
  endfunction

  always_comb begin
    base0  = clr ? '0 : acc0_q;
    base1  = clr ? '0 : acc1_q;
    wbase  = clr ? '0 : {acc1_q[UPW-1:0], acc0_q};
    wprod  = (ext_w(prod[1]) << (2*HW)) + (ext_w(prod[2]) << HW)
           + (ext_w(prod[3]) << HW) + ext_w(prod[0]);
    wsum   = wbase + wprod;
    acc0_d = acc0_q;
    acc1_d = acc1_q;
    ovf0_d = ovf0_q;
    ovf1_d = ovf1_q;
    if (en) begin
      ovf0_d = clr ? 1'b0 : ovf0_q;
      ovf1_d = clr ? 1'b0 : ovf1_q;
      case (mode)
        MODE_WIDE: begin
          acc0_d = wsum[ACW-1:0];
          acc1_d = {{(2*ACW-WW){wsum[WW-1]}}, wsum[WW-1:ACW]};
        end
        MODE_CPLX: begin
          acc0_d = base0 + ext_a(prod[0]) - ext_a(prod[1]);
          acc1_d = base1 + ext_a(prod[2]) + ext_a(prod[3]);
        end
        default: begin
          acc0_d = base0 + ext_a(prod[0]);
          acc1_d = base1 + ext_a(prod[1]);
        end
      endcase
      if (mode != MODE_WIDE) begin
        ovf0_d = ovf0_d | out_of_range(acc0_d);
        ovf1_d = ovf1_d | out_of_range(acc1_d);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0_q <= '0;
      acc1_q <= '0;
      ovf0_q <= 1'b0;
      ovf1_q <= 1'b0;
    end else if (en) begin
      acc0_q <= acc0_d;
      acc1_q <= acc1_d;
      ovf0_q <= ovf0_d;
      ovf1_q <= ovf1_d;
    end
  end

  assign acc0 = acc0_q;
  assign acc1 = acc1_q;
  assign ovf0 = ovf0_q;
  assign ovf1 = ovf1_q;
endmodule

// File: rtl/dmac_rdout.sv
module dmac_rdout #(
  parameter int HW    = 16,
  parameter int GUARD = 8
) (
  input  logic [2*HW+GUARD-1:0] acc,
  input  logic                  rnd,
  output logic [2*HW-1:0]       rd,
  output logic [HW-1:0]         hi
);
  localparam int RW  = 2 * HW;
  localparam int ACW = RW + GUARD;
  localparam logic [ACW-1:0] HALF = ACW'(1) << (HW - 1);

  logic [ACW-1:0] rounded;

  function automatic logic [RW-1:0] clamp(input logic [ACW-1:0] v);
    if (v[ACW-1:RW-1] == {(ACW-RW+1){v[RW-1]}})
      return v[RW-1:0];
    else if (v[ACW-1])
      return {1'b1, {(RW-1){1'b0}}};
    else
      return {1'b0, {(RW-1){1'b1}}};
  endfunction

  function automatic logic [HW-1:0] clamp_hi(input logic [ACW-1:0] v);
    logic [RW-1:0] c;
    c = clamp(v);
    return c[RW-1:HW];
  endfunction

  assign rounded = acc + (rnd ? HALF : '0);
  assign rd      = clamp(acc);
  assign hi      = clamp_hi(rounded);
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
  import dmac_pkg::*;
#(
  parameter int HW    = 16,
  parameter int GUARD = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [1:0]            op_mode,
  input  logic                  op_signed,
  input  logic                  op_clear,
  input  logic [3:0]            op_sel,
  input  logic [2*HW-1:0]       opa,
  input  logic [2*HW-1:0]       opb,
  input  logic                  rnd_en,
  output logic [2*HW+GUARD-1:0] acc0_o,
  output logic [2*HW+GUARD-1:0] acc1_o,
  output logic [4*HW+GUARD-1:0] wide_o,
  output logic [2*HW-1:0]       rd0_o,
  output logic [2*HW-1:0]       rd1_o,
  output logic [HW-1:0]         hi0_o,
  output logic [HW-1:0]         hi1_o,
  output logic                  ovf0_o,
  output logic                  ovf1_o,
  output logic                  out_valid
);
  localparam int XW  = HW + 1;
  localparam int PW  = 2 * XW;
  localparam int ACW = 2 * HW + GUARD;
  localparam int UPW = 2 * HW;

  mac_mode_e                      mode;
  logic [NUM_MULT-1:0][XW-1:0]    mx, my;
  logic [NUM_MULT-1:0][PW-1:0]    prod;
  logic [NUM_ACC-1:0][ACW-1:0]    acc;
  logic [NUM_ACC-1:0][2*HW-1:0]   rd;
  logic [NUM_ACC-1:0][HW-1:0]     hi;
  logic                           vld_d, vld_q;

  assign mode = mac_mode_e'(op_mode);

  dmac_route #(.HW(HW)) u_route (
    .mode (mode),
    .sgn  (op_signed),
    .sel  (op_sel),
    .opa  (opa),
    .opb  (opb),
    .mx   (mx),
    .my   (my)
  );

  for (genvar i = 0; i < NUM_MULT; i++) begin : g_mul
    dmac_mul #(.XW(XW)) u_mul (
      .mx   (mx[i]),
      .my   (my[i]),
      .prod (prod[i])
    );
  end

  dmac_acc #(.HW(HW), .GUARD(GUARD)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (op_valid),
    .mode  (mode),
    .clr   (op_clear),
    .prod  (prod),
    .acc0  (acc[0]),
    .acc1  (acc[1]),
    .ovf0  (ovf0_o),
    .ovf1  (ovf1_o)
  );

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_rd
    dmac_rdout #(.HW(HW), .GUARD(GUARD)) u_rd (
      .acc (acc[k]),
      .rnd (rnd_en),
      .rd  (rd[k]),
      .hi  (hi[k])
    );
  end

  assign vld_d = op_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign acc0_o    = acc[0];
  assign acc1_o    = acc[1];
  assign wide_o    = {acc[1][UPW-1:0], acc[0]};
  assign rd0_o     = rd[0];
  assign rd1_o     = rd[1];
  assign hi0_o     = hi[0];
  assign hi1_o     = hi[1];
  assign out_valid = vld_q;
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_mode,
  input logic        op_clear,
  input logic [39:0] acc0_o,
  input logic [39:0] acc1_o,
  input logic [31:0] rd0_o,
  input logic        ovf0_o,
  input logic        ovf1_o,
  input logic        out_valid
);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc0_o) && $stable(acc1_o) && $stable(ovf0_o) && $stable(ovf1_o)));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !out_valid);

  // R3
  wide_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == 2'b01) |=> (acc1_o[39:32] == {8{acc1_o[31]}}));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0_o && !(op_valid && op_clear)) |=> ovf0_o);

  // R8
  sat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc0_o[39:31] == {9{acc0_o[31]}}) |-> (rd0_o == acc0_o[31:0]));

  // R8
  sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc0_o[39] && acc0_o[39:31] != 9'h000) |-> (rd0_o == 32'h7FFF_FFFF));
endmodule

bind dmac_unit dmac_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_mode   (op_mode),
  .op_clear  (op_clear),
  .acc0_o    (acc0_o),
  .acc1_o    (acc1_o),
  .rd0_o     (rd0_o),
  .ovf0_o    (ovf0_o),
  .ovf1_o    (ovf1_o),
  .out_valid (out_valid)
);

// File: tb/sim_dmac_unit.sv
`timescale 1ns/1ps
module sim_dmac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // {valid, mode[1:0], signed, clear, sel[3:0], a[31:0], b[31:0]}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 1'b1, 1'b1, 4'b0000, 32'h0003_FFFE, 32'h0005_0007},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b1111, 32'h0003_FFFE, 32'h0005_0007},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b1001, 32'h0003_FFFE, 32'h0005_0007},
    {1'b1, 2'd0, 1'b0, 1'b1, 4'b0000, 32'h0000_FFFF, 32'h0000_FFFF},
    {1'b1, 2'd0, 1'b0, 1'b0, 4'b0000, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 2'd0, 1'b0, 1'b1, 4'b0000, 32'h0003_0003, 32'h8000_8000},
    {1'b1, 2'd0, 1'b1, 1'b1, 4'b0000, 32'h7FFF_7FFF, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h7FFF_7FFF, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h7FFF_7FFF, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b1, 4'b0000, 32'h8000_8000, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h8000_8000, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b0000, 32'h8000_8000, 32'h7FFF_7FFF},
    {1'b1, 2'd0, 1'b1, 1'b0, 4'b1111, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 2'd1, 1'b1, 1'b1, 4'b0000, 32'hFFFF_FFFE, 32'h0001_0003},
    {1'b1, 2'd1, 1'b1, 1'b0, 4'b0000, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 2'd1, 1'b0, 1'b1, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 2'd1, 1'b0, 1'b0, 4'b0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 2'd2, 1'b1, 1'b1, 4'b0000, 32'h0003_0002, 32'h0004_FFFF},
    {1'b1, 2'd2, 1'b0, 1'b0, 4'b0000, 32'h8000_7FFF, 32'h8000_8000},
    {1'b0, 2'd0, 1'b1, 1'b1, 4'b1111, 32'h1234_5678, 32'h9ABC_DEF0},
    {1'b1, 2'd3, 1'b1, 1'b0, 4'b0000, 32'h0002_0002, 32'h0003_0003},
    {1'b1, 2'd1, 1'b1, 1'b1, 4'b0000, 32'h0000_0001, 32'h0000_0001}
  };

  logic        clk, rst_n;
  logic        op_valid, op_signed, op_clear, rnd_en;
  logic [1:0]  op_mode;
  logic [3:0]  op_sel;
  logic [31:0] opa, opb;
  logic [39:0] acc0_o, acc1_o;
  logic [71:0] wide_o;
  logic [31:0] rd0_o, rd1_o;
  logic [15:0] hi0_o, hi1_o;
  logic        ovf0_o, ovf1_o, out_valid;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  logic [39:0] m0, m1;
  logic        mo0, mo1;

  dmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .op_signed(op_signed), .op_clear(op_clear), .op_sel(op_sel),
    .opa(opa), .opb(opb), .rnd_en(rnd_en),
    .acc0_o(acc0_o), .acc1_o(acc1_o), .wide_o(wide_o),
    .rd0_o(rd0_o), .rd1_o(rd1_o), .hi0_o(hi0_o), .hi1_o(hi1_o),
    .ovf0_o(ovf0_o), .ovf1_o(ovf1_o), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] ext40(input logic [15:0] h, input logic s);
    return s ? {{24{h[15]}}, h} : {24'h0, h};
  endfunction

  function automatic logic [31:0] sat32(input logic [39:0] v);
    if ($signed(v) > $signed(40'h00_7FFF_FFFF)) return 32'h7FFF_FFFF;
    if ($signed(v) < $signed(40'hFF_8000_0000)) return 32'h8000_0000;
    return v[31:0];
  endfunction

  function automatic logic outside(input logic [39:0] v);
    return ($signed(v) > $signed(40'h00_7FFF_FFFF)) || ($signed(v) < $signed(40'hFF_8000_0000));
  endfunction

  function automatic logic [15:0] hi_of(input logic [39:0] v, input logic r);
    logic [31:0] s;
    s = sat32(v + (r ? 40'h8000 : 40'h0));
    return s[31:16];
  endfunction

  task automatic model(input logic v, input logic [1:0] md, input logic s, input logic c,
                       input logic [3:0] sl, input logic [31:0] a, input logic [31:0] b);
    logic [39:0] b0, b1;
    logic [71:0] aw, bw, w;
    if (!v) return;
    b0 = c ? 40'h0 : m0;
    b1 = c ? 40'h0 : m1;
    if (c) begin mo0 = 1'b0; mo1 = 1'b0; end
    if (md == 2'd1) begin
      aw = s ? {{40{a[31]}}, a} : {40'h0, a};
      bw = s ? {{40{b[31]}}, b} : {40'h0, b};
      w  = (c ? 72'h0 : {m1[31:0], m0}) + aw * bw;
      m0 = w[39:0];
      m1 = {{8{w[71]}}, w[71:40]};
    end else begin
      if (md == 2'd2) begin
        m0 = b0 + ext40(a[31:16], 1'b1) * ext40(b[31:16], 1'b1)
                - ext40(a[15:0], 1'b1) * ext40(b[15:0], 1'b1);
        m1 = b1 + ext40(a[31:16], 1'b1) * ext40(b[15:0], 1'b1)
                + ext40(a[15:0], 1'b1) * ext40(b[31:16], 1'b1);
      end else begin
        m0 = b0 + ext40(sl[0] ? a[31:16] : a[15:0], s) * ext40(sl[1] ? b[31:16] : b[15:0], s);
        m1 = b1 + ext40(sl[2] ? a[31:16] : a[15:0], s) * ext40(sl[3] ? b[31:16] : b[15:0], s);
      end
      mo0 = mo0 | outside(m0);
      mo1 = mo1 | outside(m1);
    end
  endtask

  task automatic check_all(input string tag, input logic v);
    chk({"R7 out_valid ", tag}, {71'h0, out_valid}, {71'h0, v});
    chk({tag, " acc0"}, {32'h0, acc0_o}, {32'h0, m0});
    chk({tag, " acc1"}, {32'h0, acc1_o}, {32'h0, m1});
    chk({"R3 wide_o ", tag}, wide_o, {m1[31:0], m0});
    chk({"R8 rd0 ", tag}, {40'h0, rd0_o}, {40'h0, sat32(m0)});
    chk({"R8 rd1 ", tag}, {40'h0, rd1_o}, {40'h0, sat32(m1)});
    chk({"R10 ovf ", tag}, {70'h0, ovf1_o, ovf0_o}, {70'h0, mo1, mo0});
    rnd_en = 1'b0;
    #1;
    chk({"R9 hi norm ", tag}, {40'h0, hi1_o, hi0_o}, {40'h0, hi_of(m1, 1'b0), hi_of(m0, 1'b0)});
    rnd_en = 1'b1;
    #1;
    chk({"R9 hi round ", tag}, {40'h0, hi1_o, hi0_o}, {40'h0, hi_of(m1, 1'b1), hi_of(m0, 1'b1)});
    rnd_en = 1'b0;
  endtask

  task automatic apply(input logic [72:0] vec);
    string tag;
    @(negedge clk);
    op_valid  = vec[72];
    op_mode   = vec[71:70];
    op_signed = vec[69];
    op_clear  = vec[68];
    op_sel    = vec[67:64];
    opa       = vec[63:32];
    opb       = vec[31:0];
    @(posedge clk);
    @(negedge clk);
    model(vec[72], vec[71:70], vec[69], vec[68], vec[67:64], vec[63:32], vec[31:0]);
    if (!vec[72])             tag = "R6 idle hold";
    else if (vec[71:70] == 1) tag = vec[68] ? "R3 R5 R2 wide clear" : "R3 R2 wide";
    else if (vec[71:70] == 2) tag = vec[68] ? "R4 R5 complex clear" : "R4 complex";
    else                      tag = vec[68] ? "R1 R5 R2 dual clear" : "R1 R2 dual";
    op_valid = 1'b0;
    check_all(tag, vec[72]);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_mode = 2'd0; op_signed = 1'b0;
    op_clear = 1'b0; op_sel = 4'h0; opa = '0; opb = '0; rnd_en = 1'b0;
    m0 = '0; m1 = '0; mo0 = 1'b0; mo1 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset acc0", {32'h0, acc0_o}, 72'h0);
    chk("R11 reset acc1", {32'h0, acc1_o}, 72'h0);
    chk("R11 reset flags", {69'h0, out_valid, ovf1_o, ovf0_o}, 72'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) apply(VEC[i]);

    // R9 half-LSB rounding point: 3 * 0x8000 unsigned = 0x18000
    apply({1'b1, 2'd0, 1'b0, 1'b1, 4'b0000, 32'h0003_0003, 32'h8000_8000});
    rnd_en = 1'b0; #1;
    chk("R9 exact half no round", {56'h0, hi0_o}, 72'h1);
    rnd_en = 1'b1; #1;
    chk("R9 exact half rounded", {56'h0, hi0_o}, 72'h2);
    rnd_en = 1'b0;

    // R6 idle with changing operands, two cycles
    @(negedge clk);
    op_valid = 1'b0; op_clear = 1'b1; opa = 32'hFFFF_FFFF; opb = 32'hFFFF_FFFF;
    @(negedge clk);
    opa = 32'h7777_7777;
    @(negedge clk);
    chk("R6 idle acc0 unchanged", {32'h0, acc0_o}, {32'h0, m0});
    chk("R6 idle acc1 unchanged", {32'h0, acc1_o}, {32'h0, m1});

    // R11 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async reset acc0", {32'h0, acc0_o}, 72'h0);
    chk("R11 async reset acc1", {32'h0, acc1_o}, 72'h0);
    chk("R11 async reset flags", {69'h0, out_valid, ovf1_o, ovf0_o}, 72'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule